// File: doc/BRIEF.md
# Hamming(11,7) encoder and syndrome decoder

This block protects 7-bit data words with an 11-bit single-error-correcting code. An encoder path takes a data word with a valid strobe and produces the matching 11-bit codeword one clock later. An independent decoder path takes a received 11-bit word with its own valid strobe. It recomputes the four parity checks to form a 4-bit syndrome and returns the corrected data, the syndrome and one status flag, also one clock later.

Codeword positions are numbered 1 to 11, and position p sits at codeword bit p-1. The power-of-two positions (1, 2, 4, 8) carry parity. The other seven positions carry data. The decoder puts each result into one of four classes: clean, parity-bit error, corrected data-bit error, or uncorrectable. A result is uncorrectable when the syndrome points beyond position 11. Double errors are not detected as such.

Top module: `hamm_codec`

## Requirements
- R1: Data bit j is placed at the j-th non-power-of-two position in ascending order: bits 0..6 go to positions 3, 5, 6, 7, 9, 10, 11, which are codeword bits 2, 4, 5, 6, 8, 9, 10.
- R2: The parity bit at position 2^b (codeword bit 2^b - 1, b = 0..3) makes the XOR over all positions whose index has bit b set equal to zero (even parity).
- R3: `enc_valid_o` and `dec_valid_o` rise exactly one cycle after `enc_valid_i` and `dec_valid_i`. Each registered result reflects the inputs sampled at that edge.
- R4: Syndrome bit b is the XOR of the received bits at all positions whose index has bit b set. Syndrome 0 raises `no_error_o`, and the data is returned as received.
- R5: A syndrome with exactly one bit set (1, 2, 4, 8) raises `parity_err_o`, and the data bits are returned unchanged.
- R6: A syndrome of 3, 5, 6, 7, 9, 10 or 11 raises `corrected_o`, and the received bit at that position is inverted before the data is extracted (for example, syndrome 6 fixes position 6, which is data bit 2).
- R7: A syndrome of 12 to 15 raises `uncorrectable_o`, and the data bits are returned as received, without any bit inverted.
- R8: While `dec_valid_o` is high, exactly one of the four status flags is high. While it is low, all four are low.
- R9: After reset, both valid outputs, all flags and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 7 | Data word to encode |
| enc_valid_o | output | 1 | Codeword valid |
| enc_code_o | output | 11 | Codeword, bit p-1 is position p |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 11 | Received codeword |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 7 | Corrected data |
| dec_syndrome_o | output | 4 | Syndrome (error position) |
| no_error_o | output | 1 | Syndrome zero |
| parity_err_o | output | 1 | Error in a parity position |
| corrected_o | output | 1 | Data-position error corrected |
| uncorrectable_o | output | 1 | Syndrome beyond position 11 |

## Verification
The bench flips every one of the 11 positions of several encoded words. A decoder that swapped the parity and data classes, or that used an off-by-one flip index, would return wrong data or raise the wrong flag. Double errors on the pairs 4+8, 5+9 and 7+8 drive syndromes 12, 12 and 15. A design that tried to correct these would write out of range or corrupt the data, and a design that treated them as clean would return the wrong flag. The encoder table checks values where a wrong data-to-position mapping or a parity mask that includes its own position would change specific codeword bits. Idle cycles after each result check that a stale flag does not stay high.

// File: rtl/hamm_pkg.sv
package hamm_pkg;
  localparam int DATA_W = 7;
  localparam int PAR_W  = 4;
  localparam int CODE_W = DATA_W + PAR_W;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_PARITY,
    CLS_DATA,
    CLS_UNCORR
  } err_cls_e;

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // data index carried by position p (p not a power of two)
  function automatic int data_idx(int p);
    int n;
    n = 0;
    for (int q = 1; q < p; q++) if (!is_pow2(q)) n++;
    return n;
  endfunction

  // positions covered by check b, parity position included
  function automatic logic [CODE_W-1:0] cover_mask(int b);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) if (((p >> b) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hamm_encoder.sv
module hamm_encoder
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  logic [CW-1:0] placed;
  logic [PW-1:0] par;

  for (genvar p = 1; p <= CW; p++) begin : g_pos
    if (is_pow2(p)) begin : g_par
      assign placed[p-1] = 1'b0;
      assign code_o[p-1] = par[$clog2(p)];
    end else begin : g_dat
      assign placed[p-1] = data_i[data_idx(p)];
      assign code_o[p-1] = placed[p-1];
    end
  end

  for (genvar b = 0; b < PW; b++) begin : g_chk
    assign par[b] = ^(placed & CW'(cover_mask(b)));
  end
endmodule

// File: rtl/hamm_syndrome.sv
module hamm_syndrome
  import hamm_pkg::*;
#(
  parameter int PW = PAR_W,
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code_i,
  output logic [PW-1:0] syn_o
);
  for (genvar b = 0; b < PW; b++) begin : g_chk
    assign syn_o[b] = ^(code_i & CW'(cover_mask(b)));
  end
endmodule

// File: rtl/hamm_corrector.sv
module hamm_corrector
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic [CW-1:0] code_i,
  input  logic [PW-1:0] syn_i,
  output err_cls_e      cls_o,
  output logic [DW-1:0] data_o
);
  logic [CW-1:0] flip;
  logic [CW-1:0] fixed;

  always_comb begin
    if (syn_i == '0)                     cls_o = CLS_NONE;
    else if ($countones(syn_i) == 1)     cls_o = CLS_PARITY;
    else if (int'(syn_i) > CW)           cls_o = CLS_UNCORR;
    else                                 cls_o = CLS_DATA;
  end

  always_comb begin
    flip = '0;
    for (int p = 1; p <= CW; p++)
      if (cls_o == CLS_DATA && int'(syn_i) == p) flip[p-1] = 1'b1;
  end

  assign fixed = code_i ^ flip;

  for (genvar p = 1; p <= CW; p++) begin : g_ext
    if (!is_pow2(p)) begin : g_dat
      assign data_o[data_idx(p)] = fixed[p-1];
    end
  end
endmodule

// File: rtl/hamm_codec.sv
module hamm_codec
  import hamm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [PAR_W-1:0]  dec_syndrome_o,
  output logic              no_error_o,
  output logic              parity_err_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  logic [CODE_W-1:0] enc_code;
  logic [PAR_W-1:0]  syn;
  err_cls_e          cls;
  logic [DATA_W-1:0] dec_data;

  hamm_encoder #(.DW(DATA_W), .PW(PAR_W)) u_enc (
    .data_i(enc_data_i), .code_o(enc_code)
  );

  hamm_syndrome #(.PW(PAR_W), .CW(CODE_W)) u_syn (
    .code_i(dec_code_i), .syn_o(syn)
  );

  hamm_corrector #(.DW(DATA_W), .PW(PAR_W)) u_cor (
    .code_i(dec_code_i), .syn_i(syn), .cls_o(cls), .data_o(dec_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o     <= 1'b0;
      dec_data_o      <= '0;
      dec_syndrome_o  <= '0;
      no_error_o      <= 1'b0;
      parity_err_o    <= 1'b0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else begin
      dec_valid_o     <= dec_valid_i;
      no_error_o      <= dec_valid_i && cls == CLS_NONE;
      parity_err_o    <= dec_valid_i && cls == CLS_PARITY;
      corrected_o     <= dec_valid_i && cls == CLS_DATA;
      uncorrectable_o <= dec_valid_i && cls == CLS_UNCORR;
      if (dec_valid_i) begin
        dec_data_o     <= dec_data;
        dec_syndrome_o <= syn;
      end
    end
  end

  // R3
  a_r3_enc_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);
  a_r3_dec_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  // R1: data bit 0 lands at position 3
  a_r1_lsb_at_pos3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_code_o[2] == $past(enc_data_i[0]));
  // R2: output codeword satisfies check 0
  a_r2_check0_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> ^(enc_code_o & cover_mask(0)) == 1'b0);
  // R8
  a_r8_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $countones({no_error_o, parity_err_o, corrected_o, uncorrectable_o}) == 1);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> {no_error_o, parity_err_o, corrected_o, uncorrectable_o} == 4'b0);
  // R7
  a_r7_uncorr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorrectable_o |-> int'(dec_syndrome_o) > CODE_W);
  // R5
  a_r5_parity_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> $countones(dec_syndrome_o) == 1);
endmodule

// File: tb/hamm_codec_tb.sv
module hamm_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic [6:0]  enc_data_i = '0;
  logic        enc_valid_o;
  logic [10:0] enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [10:0] dec_code_i = '0;
  logic        dec_valid_o;
  logic [6:0]  dec_data_o;
  logic [3:0]  dec_syndrome_o;
  logic        no_error_o, parity_err_o, corrected_o, uncorrectable_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hamm_codec u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o),
    .no_error_o(no_error_o), .parity_err_o(parity_err_o),
    .corrected_o(corrected_o), .uncorrectable_o(uncorrectable_o)
  );

  // hand-worked encoder vectors (R1, R2)
  localparam int NV = 5;
  localparam logic [6:0]  VEC_D [NV] = '{7'h00, 7'h01, 7'h08, 7'h40, 7'h7F};
  localparam logic [10:0] VEC_C [NV] = '{11'h000, 11'h007, 11'h04B, 11'h483, 11'h7FF};

  localparam int DPOS [7] = '{3, 5, 6, 7, 9, 10, 11};

  function automatic logic [10:0] ref_enc(logic [6:0] d);
    logic [10:0] c;
    c = '0;
    for (int j = 0; j < 7; j++) c[DPOS[j]-1] = d[j];
    for (int b = 0; b < 4; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p <= 11; p++) if (((p >> b) & 1) == 1) x ^= c[p-1];
      c[(1 << b) - 1] = x;
    end
    return c;
  endfunction

  function automatic logic [6:0] ref_ext(logic [10:0] c);
    logic [6:0] d;
    for (int j = 0; j < 7; j++) d[j] = c[DPOS[j]-1];
    return d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic encode(logic [6:0] d);
    @(negedge clk);
    enc_data_i = d; enc_valid_i = 1'b1;
    @(negedge clk);
    enc_valid_i = 1'b0;
  endtask

  // flags packed {no_error, parity, corrected, uncorrectable}
  task automatic decode(logic [10:0] c, logic [6:0] exp_d, logic [3:0] exp_s,
                        logic [3:0] exp_f, string req);
    @(negedge clk);
    dec_code_i = c; dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check({req, " valid"}, 32'(dec_valid_o), 32'd1);
    check({req, " data"}, 32'(dec_data_o), 32'(exp_d));
    check({req, " syndrome"}, 32'(dec_syndrome_o), 32'(exp_s));
    check({req, " flags"}, 32'({no_error_o, parity_err_o, corrected_o, uncorrectable_o}), 32'(exp_f));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset outputs",
          32'({enc_valid_o, dec_valid_o, no_error_o, parity_err_o, corrected_o, uncorrectable_o}), 32'd0);
    check("R9 reset data", 32'({enc_code_o, dec_data_o, dec_syndrome_o}), 32'd0);
    rst_n = 1'b1;

    // R1 R2 R3 encoder table
    for (int i = 0; i < NV; i++) begin
      encode(VEC_D[i]);
      check("R3 enc valid", 32'(enc_valid_o), 32'd1);
      check("R1 R2 codeword", 32'(enc_code_o), 32'(VEC_C[i]));
    end
    @(negedge clk);
    check("R3 enc valid drops", 32'(enc_valid_o), 32'd0);

    // extra encoder patterns against computed reference
    for (int v = 0; v < 128; v += 19) begin
      encode(7'(v));
      check("R1 R2 codeword ref", 32'(enc_code_o), 32'(ref_enc(7'(v))));
    end

    // R4 clean words
    for (int i = 0; i < NV; i++)
      decode(VEC_C[i], VEC_D[i], 4'd0, 4'b1000, "R4 clean");
    @(negedge clk);
    check("R8 flags idle", 32'({dec_valid_o, no_error_o, parity_err_o, corrected_o, uncorrectable_o}), 32'd0);

    // R5 R6 single flips over all positions
    for (int i = 0; i < NV; i++) begin
      for (int p = 1; p <= 11; p++) begin
        logic [10:0] c;
        c = VEC_C[i];
        c[p-1] = ~c[p-1];
        if ((p & (p - 1)) == 0)
          decode(c, VEC_D[i], 4'(p), 4'b0100, "R5 parity flip");
        else
          decode(c, VEC_D[i], 4'(p), 4'b0010, "R6 data flip");
      end
    end
    // R6 example: syndrome 6 fixes data bit 2
    decode(11'h000 ^ 11'h020, 7'h00, 4'd6, 4'b0010, "R6 pos6");

    // R7 double flips giving syndrome 12..15
    begin
      logic [10:0] c;
      c = VEC_C[2] ^ 11'h088; // positions 4,8
      decode(c, VEC_D[2], 4'd12, 4'b0001, "R7 pos4+8");
      c = VEC_C[3] ^ 11'h110; // positions 5,9
      decode(c, ref_ext(c), 4'd12, 4'b0001, "R7 pos5+9");
      check("R7 data raw", 32'(dec_data_o), 32'(VEC_D[3] ^ 7'h12));
      c = VEC_C[4] ^ 11'h0C0; // positions 7,8
      decode(c, VEC_D[4] ^ 7'h08, 4'd15, 4'b0001, "R7 pos7+8");
    end
    @(negedge clk);
    check("R8 flags idle end", 32'({dec_valid_o, no_error_o, parity_err_o, corrected_o, uncorrectable_o}), 32'd0);

    // R3 back-to-back decode
    @(negedge clk);
    dec_code_i = VEC_C[1]; dec_valid_i = 1'b1;
    @(negedge clk);
    check("R3 b2b first", 32'(dec_data_o), 32'(VEC_D[1]));
    dec_code_i = VEC_C[4] ^ 11'h400;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check("R3 b2b second", 32'({dec_data_o, corrected_o}), 32'({VEC_D[4], 1'b1}));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule